// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This unit rebuilds the four status flags (negative, zero, carry, overflow) from a saved description of the last flag-setting operation. That description is an operation code and three operand words. The unit does not observe an ALU as the operation runs. It recomputes the flags when they are needed. This lets an upstream pipeline record cheap descriptors and leave flag materialisation to a later point.

Every cycle the unit takes one descriptor and returns three results, all registered, one cycle later:

- a full status word with the flags placed in their architectural bit positions;
- a word carrying only the carry flag;
- the answer to a condition query.

The query selector packs a 4-bit condition code above a 4-bit operation code. The unit evaluates that operation over the same three operand words, then tests the requested condition against the resulting flags.

Top module: `flag_eval_unit`

## Requirements
- R1: The status word places N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Every other bit is zero. Results appear on the clock edge after the inputs are sampled.
- R2: While reset is asserted, all outputs are zero.
- R3: Operation code 0 (pass-through) copies bits 31:28 of operand 1 into bits 31:28 of the status word. All other bits of operand 1 are ignored.
- R4: Codes 1 (32-bit add) and 2 (64-bit add) add operand 1 and operand 2. N is the result sign, Z is set on a zero result, C is the unsigned carry out and V is the signed overflow.
- R5: Codes 3 (32-bit subtract) and 4 (64-bit subtract) compute operand 1 minus operand 2. C is 1 exactly when operand 1 is unsigned greater than or equal to operand 2.
- R6: Codes 5 (32-bit add-with-carry) and 6 (64-bit add-with-carry) add operand 1, operand 2 and bit 0 of operand 3.
- R7: Codes 7 (32-bit subtract-with-carry) and 8 (64-bit subtract-with-carry) compute operand 1 plus the bitwise inverse of operand 2 plus bit 0 of operand 3.
- R8: Codes 9 (32-bit logical) and 10 (64-bit logical) treat operand 1 as the finished result. N is its sign bit, Z is set when it is zero, and C and V are both 0.
- R9: Codes 11 to 15 produce a status word of all zeros.
- R10: The carry word holds the C flag of the main operation in bit 0, with all other bits zero.
- R11: The query selector holds the condition code in bits 7:4 and the operation code in bits 3:0. The condition codes are:

  | Code | True when |
  |------|-----------|
  | 0 | Z |
  | 1 | not Z |
  | 2 | C |
  | 3 | not C |
  | 4 | N |
  | 5 | not N |
  | 6 | V |
  | 7 | not V |
  | 8 | C and not Z |
  | 9 | not C or Z |
  | 10 | N equals V |
  | 11 | N differs from V |
  | 12 | not Z and N equals V |
  | 13 | Z or N differs from V |
  | 14, 15 | always true |

- R12: The 32-bit codes use only bits 31:0 of operands 1 and 2. The upper bits have no effect on any output. N is taken from bit 31 of the 32-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opc_i | input | 4 | Operation code of the recorded descriptor |
| dep1_i | input | 64 | Operand 1: left argument, finished result, or packed flags |
| dep2_i | input | 64 | Operand 2: right argument |
| dep3_i | input | 64 | Operand 3: previous carry in bit 0 |
| query_sel_i | input | 8 | Condition code (7:4) and operation code (3:0) for the query |
| flags_o | output | 64 | Status word with N, Z, C, V at bits 31..28 |
| carry_o | output | 64 | C flag in bit 0 |
| cond_hit_o | output | 1 | Result of the condition query |

## Verification
The bench builds the unit with its default widths: a 64-bit word and a 32-bit narrow path. With these widths, both adder instances can be driven to their carry and overflow boundaries by operands such as 0x7FFFFFFF + 1 and all-ones + 1. Garbage placed in the upper half of the operands shows whether the narrow codes are isolated from it. Every condition code is swept against all sixteen flag patterns through the pass-through code. Randomised descriptors, whose query operation differs from the main operation, exercise the two flag engines independently.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

    typedef enum logic [3:0] {
        OPC_COPY  = 4'd0,
        OPC_ADD_W = 4'd1,
        OPC_ADD_X = 4'd2,
        OPC_SUB_W = 4'd3,
        OPC_SUB_X = 4'd4,
        OPC_ADC_W = 4'd5,
        OPC_ADC_X = 4'd6,
        OPC_SBC_W = 4'd7,
        OPC_SBC_X = 4'd8,
        OPC_LOG_W = 4'd9,
        OPC_LOG_X = 4'd10
    } opc_e;

    typedef enum logic [3:0] {
        TST_EQ   = 4'd0,
        TST_NE   = 4'd1,
        TST_HS   = 4'd2,
        TST_LO   = 4'd3,
        TST_NEG  = 4'd4,
        TST_POS  = 4'd5,
        TST_OVF  = 4'd6,
        TST_NOVF = 4'd7,
        TST_UGT  = 4'd8,
        TST_ULE  = 4'd9,
        TST_SGE  = 4'd10,
        TST_SLT  = 4'd11,
        TST_SGT  = 4'd12,
        TST_SLE  = 4'd13,
        TST_ALW  = 4'd14,
        TST_ALW2 = 4'd15
    } tst_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int POS_N   = 31;
    localparam int POS_Z   = 30;
    localparam int POS_C   = 29;
    localparam int POS_V   = 28;
    localparam int OPC_W   = 4;
    localparam int TST_W   = 4;
    localparam int SEL_W   = OPC_W + TST_W;

endpackage

// File: rtl/nzcv_adder.sv
module nzcv_adder
    import flag_eval_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output nzcv_t        flags_o
);
    localparam int MSB = W - 1;

    logic [W:0] total;

    always_comb begin
        total     = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        flags_o.n = total[MSB];
        flags_o.z = (total[MSB:0] == '0);
        flags_o.c = total[W];
        flags_o.v = (a_i[MSB] == b_i[MSB]) && (total[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/flag_core.sv
module flag_core
    import flag_eval_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [WORD_W-1:0] dep1_i,
    input  logic [WORD_W-1:0] dep2_i,
    input  logic [WORD_W-1:0] dep3_i,
    output nzcv_t             flags_o
);
    localparam int NUM_PATHS = 2;

    logic              invert_b;
    logic              take_cin;
    logic              carry_in;
    logic [WORD_W-1:0] operand_b;
    nzcv_t             path_flags [NUM_PATHS];
    logic [WORD_W-2:0] unused_dep3;

    assign unused_dep3 = dep3_i[WORD_W-1:1];

    always_comb begin
        invert_b = 1'b0;
        take_cin = 1'b0;
        unique case (opc_i)
            OPC_SUB_W, OPC_SUB_X: invert_b = 1'b1;
            OPC_ADC_W, OPC_ADC_X: take_cin = 1'b1;
            OPC_SBC_W, OPC_SBC_X: begin
                invert_b = 1'b1;
                take_cin = 1'b1;
            end
            default: ;
        endcase
        carry_in  = take_cin ? dep3_i[0] : invert_b;
        operand_b = invert_b ? ~dep2_i : dep2_i;
    end

    // path 0 is narrow, path 1 is full width
    for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
        localparam int PW = (k == 0) ? NARROW_W : WORD_W;
        nzcv_adder #(.W(PW)) u_add (
            .a_i    (dep1_i[PW-1:0]),
            .b_i    (operand_b[PW-1:0]),
            .cin_i  (carry_in),
            .flags_o(path_flags[k])
        );
    end

    always_comb begin
        flags_o = '0;
        unique case (opc_i)
            OPC_COPY: flags_o = dep1_i[POS_N:POS_V];
            OPC_ADD_W, OPC_SUB_W, OPC_ADC_W, OPC_SBC_W: flags_o = path_flags[0];
            OPC_ADD_X, OPC_SUB_X, OPC_ADC_X, OPC_SBC_X: flags_o = path_flags[1];
            OPC_LOG_W: begin
                flags_o.n = dep1_i[NARROW_W-1];
                flags_o.z = (dep1_i[NARROW_W-1:0] == '0);
            end
            OPC_LOG_X: begin
                flags_o.n = dep1_i[WORD_W-1];
                flags_o.z = (dep1_i == '0);
            end
            default: flags_o = '0;
        endcase
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import flag_eval_pkg::*;
(
    input  logic [TST_W-1:0] tst_i,
    input  nzcv_t            flags_i,
    output logic             hit_o
);
    logic sign_agree;

    always_comb begin
        sign_agree = (flags_i.n == flags_i.v);
        hit_o      = 1'b1;
        unique case (tst_e'(tst_i))
            TST_EQ:   hit_o = flags_i.z;
            TST_NE:   hit_o = !flags_i.z;
            TST_HS:   hit_o = flags_i.c;
            TST_LO:   hit_o = !flags_i.c;
            TST_NEG:  hit_o = flags_i.n;
            TST_POS:  hit_o = !flags_i.n;
            TST_OVF:  hit_o = flags_i.v;
            TST_NOVF: hit_o = !flags_i.v;
            TST_UGT:  hit_o = flags_i.c && !flags_i.z;
            TST_ULE:  hit_o = !flags_i.c || flags_i.z;
            TST_SGE:  hit_o = sign_agree;
            TST_SLT:  hit_o = !sign_agree;
            TST_SGT:  hit_o = !flags_i.z && sign_agree;
            TST_SLE:  hit_o = flags_i.z || !sign_agree;
            TST_ALW, TST_ALW2: hit_o = 1'b1;
            default:  hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/flag_eval_unit.sv
module flag_eval_unit
    import flag_eval_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        opc_i,
    input  logic [WORD_W-1:0] dep1_i,
    input  logic [WORD_W-1:0] dep2_i,
    input  logic [WORD_W-1:0] dep3_i,
    input  logic [7:0]        query_sel_i,
    output logic [WORD_W-1:0] flags_o,
    output logic [WORD_W-1:0] carry_o,
    output logic              cond_hit_o
);
    localparam logic [WORD_W-1:0] FLAG_MASK = {{(WORD_W-POS_N-1){1'b0}}, 4'hF, {POS_V{1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] carry;
        logic              hit;
    } eval_t;

    nzcv_t main_flags;
    nzcv_t query_flags;
    logic  query_hit;
    eval_t eval_d, eval_q;

    flag_core #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_main (
        .opc_i  (opc_i),
        .dep1_i (dep1_i),
        .dep2_i (dep2_i),
        .dep3_i (dep3_i),
        .flags_o(main_flags)
    );

    flag_core #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_query (
        .opc_i  (query_sel_i[OPC_W-1:0]),
        .dep1_i (dep1_i),
        .dep2_i (dep2_i),
        .dep3_i (dep3_i),
        .flags_o(query_flags)
    );

    cond_eval u_cond (
        .tst_i  (query_sel_i[SEL_W-1:OPC_W]),
        .flags_i(query_flags),
        .hit_o  (query_hit)
    );

    always_comb begin
        eval_d                   = '0;
        eval_d.flags[POS_N]      = main_flags.n;
        eval_d.flags[POS_Z]      = main_flags.z;
        eval_d.flags[POS_C]      = main_flags.c;
        eval_d.flags[POS_V]      = main_flags.v;
        eval_d.carry[0]          = main_flags.c;
        eval_d.hit               = query_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) eval_q <= '0;
        else         eval_q <= eval_d;
    end

    assign flags_o    = eval_q.flags;
    assign carry_o    = eval_q.carry;
    assign cond_hit_o = eval_q.hit;

    AST_RESERVED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o & ~FLAG_MASK) == '0); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        !rst_ni |=> (flags_o == '0 && carry_o == '0 && !cond_hit_o)); // R2
    AST_COPY_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i == OPC_COPY) |=> (flags_o[POS_N:POS_V] == $past(dep1_i[POS_N:POS_V]))); // R3
    AST_SUB_EQUAL_SETS_ZC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i == OPC_SUB_X && dep1_i == dep2_i) |=> (flags_o[POS_Z] && flags_o[POS_C])); // R5
    AST_LOGIC_CLEARS_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i == OPC_LOG_W || opc_i == OPC_LOG_X) |=> (!flags_o[POS_C] && !flags_o[POS_V])); // R8
    AST_UNUSED_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i > OPC_LOG_X) |=> (flags_o == '0)); // R9
    AST_CARRY_MIRRORS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (carry_o[WORD_W-1:1] == '0) && (carry_o[0] == flags_o[POS_C])); // R10
    AST_ALWAYS_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (query_sel_i[7:5] == 3'b111) |=> cond_hit_o); // R11

endmodule

// File: tb/flag_eval_unit_tb_top.sv
`timescale 1ns/1ps
module flag_eval_unit_tb_top;

    typedef struct {
        logic [63:0] flags;
        logic [63:0] carry;
        logic        hit;
        string       tag;
        int          op;
        int          tst;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opc = '0;
    logic [63:0] d1 = '0, d2 = '0, d3 = '0;
    logic [7:0]  sel = '0;
    logic [63:0] flags_w, carry_w;
    logic        hit_w;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    flag_eval_unit dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .opc_i      (opc),
        .dep1_i     (d1),
        .dep2_i     (d2),
        .dep3_i     (d3),
        .query_sel_i(sel),
        .flags_o    (flags_w),
        .carry_o    (carry_w),
        .cond_hit_o (hit_w)
    );

    // signed-range overflow model, independent of sign-bit comparisons
    function automatic logic [3:0] arith(input logic [63:0] a, input logic [63:0] b,
                                         input logic cin, input bit narrow);
        logic [3:0] r;
        if (narrow) begin
            logic [32:0] u;
            logic signed [33:0] s;
            u = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'b0, cin};
            s = $signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]}) + $signed({33'b0, cin});
            r = {u[31], u[31:0] == 32'b0, u[32], !(s[33:31] == 3'b000 || s[33:31] == 3'b111)};
        end else begin
            logic [64:0] u;
            logic signed [65:0] s;
            u = {1'b0, a} + {1'b0, b} + {64'b0, cin};
            s = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}) + $signed({65'b0, cin});
            r = {u[63], u[63:0] == 64'b0, u[64], !(s[65:63] == 3'b000 || s[65:63] == 3'b111)};
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_nzcv(input int op, input logic [63:0] a,
                                            input logic [63:0] b, input logic [63:0] c);
        case (op)
            0:  return a[31:28];
            1:  return arith(a, b, 1'b0, 1);
            2:  return arith(a, b, 1'b0, 0);
            3:  return arith(a, ~b, 1'b1, 1);
            4:  return arith(a, ~b, 1'b1, 0);
            5:  return arith(a, b, c[0], 1);
            6:  return arith(a, b, c[0], 0);
            7:  return arith(a, ~b, c[0], 1);
            8:  return arith(a, ~b, c[0], 0);
            9:  return {a[31], a[31:0] == 32'b0, 2'b00};
            10: return {a[63], a == 64'b0, 2'b00};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic ref_cond(input int t, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (t)
            0: return z;          1: return !z;
            2: return c;          3: return !c;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return c & !z;     9: return !c | z;
            10: return n ~^ v;    11: return n ^ v;
            12: return !z & (n ~^ v);
            13: return z | (n ^ v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string op_req(input int op);
        case (op)
            0: return "R3";
            1, 2: return "R4";
            3, 4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            9, 10: return "R8";
            default: return "R9";
        endcase
    endfunction

    // driver: apply one descriptor and push its prediction
    task automatic send(input int op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input int t, input int qop, input string tag);
        exp_t e;
        logic [3:0] f;
        @(negedge clk);
        opc = 4'(op); d1 = a; d2 = b; d3 = c; sel = {4'(t), 4'(qop)};
        f = ref_nzcv(op, a, b, c);
        e.flags = {32'b0, f, 28'b0};
        e.carry = {63'b0, f[1]};
        e.hit   = ref_cond(t, ref_nzcv(qop, a, b, c));
        e.tag   = (tag == "") ? op_req(op) : tag;
        e.op    = op;
        e.tst   = t;
        sb_q.push_back(e);
    endtask

    // monitor: compare one item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (flags_w !== e.flags) begin
                    n_fail++;
                    $display("FAIL %s/R1 op=%0d flags got %h exp %h", e.tag, e.op, flags_w, e.flags);
                end
                n_checks++;
                if (carry_w !== e.carry) begin
                    n_fail++;
                    $display("FAIL R10 op=%0d carry got %h exp %h", e.op, carry_w, e.carry);
                end
                n_checks++;
                if (hit_w !== e.hit) begin
                    n_fail++;
                    $display("FAIL R11 tst=%0d hit got %b exp %b", e.tst, hit_w, e.hit);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        n_checks++;
        if (flags_w !== 64'b0 || carry_w !== 64'b0 || hit_w !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset outputs got %h/%h/%b exp 0/0/0", flags_w, carry_w, hit_w);
        end
        rst_n = 1'b1;

        // R3: copy with garbage elsewhere
        send(0, 64'hDEAD_BEEF_A123_4567, 64'h0, 64'h0, 0, 0, "R3");
        // R4: 32-bit overflow and carry; 64-bit boundaries
        send(1, 64'h7FFF_FFFF, 64'h1, 64'h0, 6, 1, "R4");
        send(1, 64'hFFFF_FFFF, 64'h1, 64'h0, 0, 1, "R4");
        send(2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 2, 2, "R4");
        send(2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 11, 2, "R4");
        // R12: upper half garbage must not influence narrow codes
        send(1, 64'hFFFF_0000_0000_0001, 64'h1234_5678_0000_0001, 64'h0, 4, 1, "R12");
        send(3, 64'hAAAA_AAAA_0000_0005, 64'h5555_5555_0000_0005, 64'h0, 0, 3, "R12");
        send(9, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'h0, 0, 9, "R12");
        // R5: equal, less, greater
        send(4, 64'h10, 64'h10, 64'h0, 0, 4, "R5");
        send(4, 64'h5, 64'h9, 64'h0, 3, 4, "R5");
        send(3, 64'h9, 64'h5, 64'h0, 8, 3, "R5");
        // R6 / R7: carry-in effect
        send(6, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'h1, 0, 6, "R6");
        send(5, 64'h7FFF_FFFE, 64'h1, 64'h1, 6, 5, "R6");
        send(8, 64'h5, 64'h5, 64'h0, 9, 8, "R7");
        send(7, 64'h5, 64'h4, 64'h0, 0, 7, "R7");
        // R8: logical results
        send(10, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 4, 10, "R8");
        send(10, 64'h0, 64'h0, 64'h0, 0, 10, "R8");
        // R9: unused codes
        send(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1, 1, 12, "R9");
        send(15, 64'hF000_0000, 64'h0, 64'h0, 14, 15, "R9");
        // R11: every condition against every flag pattern via copy
        for (int t = 0; t < 16; t++)
            for (int f = 0; f < 16; f++)
                send(0, {32'h0, 4'(f), 28'h0}, 64'h0, 64'h0, t, 0, "R11");
        // random descriptors, query op independent of main op
        for (int i = 0; i < 400; i++)
            send($urandom_range(0, 15), {$urandom, $urandom}, {$urandom, $urandom},
                 {63'b0, 1'($urandom)}, $urandom_range(0, 15), $urandom_range(0, 15), "");

        @(negedge clk);
        opc = 4'd0; d1 = '0; d2 = '0; d3 = '0; sel = '0;
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule